// File: doc/BRIEF.md
# Streaming Single-Pattern String Matcher with Dual Comparators

This block scans a byte stream for every occurrence of one stored pattern using the prefix-function method. The method advances through the text without rescanning it. The pattern characters, the pattern length and the per-prefix fallback table are held in small writable storage. Software computes the table off chip and loads it through a simple write port while the block is idle, so a new pattern needs no rebuild of the hardware.

Characters arrive on a valid/ready stream with a last-beat marker and enter a small FIFO. Each cycle two comparators look at the FIFO head at the same time. One checks it against the pattern character at the current matched-prefix length `j`. The other checks it against the character at the fallback position `fail[j]`.

- If the first comparator hits, `j` advances.
- If the first misses and the second hits, `j` becomes `fail[j]+1` and the character is consumed.
- If `j` is zero and the character misses, the character is consumed and `j` stays zero.
- If both comparators miss, `j` drops to `fail[j]` and the character waits at the head of the FIFO.

A complete match raises a one-cycle pulse with the stream position of the last character. `j` then continues from `fail[len]`, so overlapping occurrences are also found.

A controller with four states sequences each stream:
- IDLE: storage may be written, and the first accepted beat starts a stream. A beat without the last marker goes to RUN. A beat with the marker goes straight to DRAIN.
- RUN: further beats are accepted. The beat carrying the last marker moves the controller to DRAIN.
- DRAIN: no input is taken. When the FIFO is empty the controller moves to FINISH.
- FINISH: lasts one cycle. It raises `done`, clears `j` and the position counter, and returns to IDLE.

Top module: `kmp_stream_matcher`

## Requirements
- R1: Every occurrence of the stored pattern in the stream, including overlapping ones, produces exactly one single-cycle `match_pulse`. With each pulse, `match_pos` gives the 0-based index of the occurrence's last character, counted from the first beat of the current stream. Pulses appear in stream order.
- R2: After reset, `match_pulse` and `done` are low, and `in_ready` is high while `cfg_we` is low.
- R3: The FIFO holds FIFO_DEPTH characters. `in_ready` goes low while it is full. Every accepted character is examined exactly once and in order, also when the FIFO fills because of fallback cycles.
- R4: A write takes effect only in IDLE, and `in_ready` is low in IDLE while `cfg_we` is high. The `cfg_sel` field selects what `cfg_data` is written to:
  - 0: the pattern character at index `cfg_addr`.
  - 1: the fallback entry for the prefix of length `cfg_addr`. This is the length of the longest proper prefix of that prefix that is also its suffix.
  - 2: the pattern length.
- R5: A write issued from the first accepted beat of a stream until `done` has no effect on the stored pattern, table or length.
- R6: `done` is a one-cycle pulse. It comes after the beat with `in_last` has been consumed and the FIFO is empty. No beat is accepted between that beat and `done`. The next stream counts positions from 0 again.
- R7: A pattern length of 0 never matches. A pattern of MAX_LEN (16) characters is found.
- R8: With a source that offers a beat every cycle, `done` follows the first accepted beat of an n-character stream within 2n+4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Storage write request |
| cfg_sel | input | 2 | Write target: 0 character, 1 fallback entry, 2 length |
| cfg_addr | input | LEN_W (5) | Character index or prefix length |
| cfg_data | input | CHAR_W (8) | Write data |
| in_valid | input | 1 | Stream beat valid |
| in_data | input | CHAR_W (8) | Stream character |
| in_last | input | 1 | Marks the final beat of the stream |
| in_ready | output | 1 | Block can take a beat this cycle |
| match_pulse | output | 1 | One-cycle occurrence indication |
| match_pos | output | POS_W (16) | Index of the occurrence's last character |
| done | output | 1 | One-cycle end-of-stream indication |

## Verification
The assertions assume that the fallback table loaded for a pattern is the true prefix-function table. In particular, each entry is strictly smaller than its prefix length, which keeps `j` below the pattern length. They also assume that every stream ends with a beat carrying `in_last` before a new stream starts. The bench computes every table it loads from the pattern with its own border search. It always closes a stream with a last beat and waits for `done` before starting the next one. The only writes it issues outside IDLE are the deliberate ignored-write test.

// File: rtl/kmp_pkg.sv
package kmp_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_RUN    = 2'd1,
        S_DRAIN  = 2'd2,
        S_FINISH = 2'd3
    } mstate_t;

    typedef enum logic [1:0] {
        SEL_CHAR = 2'd0,
        SEL_FAIL = 2'd1,
        SEL_LEN  = 2'd2
    } cfg_sel_t;

    typedef enum logic [2:0] {
        STEP_NONE     = 3'd0,
        STEP_ADVANCE  = 3'd1,
        STEP_FALLBACK = 3'd2,
        STEP_SKIP     = 3'd3,
        STEP_RETREAT  = 3'd4
    } step_t;

endpackage

// File: rtl/kmp_char_fifo.sv
module kmp_char_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] count;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= wrap_inc(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= wrap_inc(rd_ptr);
            end
            unique case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_comb begin
        head  = mem[rd_ptr];
        empty = (count == '0);
        full  = (count == CW'(DEPTH));
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    assert_push_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push || pop);

endmodule

// File: rtl/kmp_pattern_store.sv
module kmp_pattern_store
    import kmp_pkg::*;
#(
    parameter int CHAR_W  = 8,
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [LEN_W-1:0]  wr_addr,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic [LEN_W-1:0]  j,
    output logic [CHAR_W-1:0] pat_j,
    output logic [CHAR_W-1:0] pat_fj,
    output logic [LEN_W-1:0]  fail_j,
    output logic [LEN_W-1:0]  fail_len,
    output logic [LEN_W-1:0]  len
);
    localparam int PIDX_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

    logic [CHAR_W-1:0] pat_mem  [MAX_LEN];
    logic [LEN_W-1:0]  fail_mem [MAX_LEN + 1];
    logic [LEN_W-1:0]  len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_LEN; i++) begin
                pat_mem[i] <= '0;
            end
            for (int i = 0; i <= MAX_LEN; i++) begin
                fail_mem[i] <= '0;
            end
            len_q <= '0;
        end else if (wr_en) begin
            unique case (cfg_sel_t'(wr_sel))
                SEL_CHAR: begin
                    if (wr_addr < LEN_W'(MAX_LEN)) begin
                        pat_mem[wr_addr[PIDX_W-1:0]] <= wr_data;
                    end
                end
                SEL_FAIL: begin
                    if (wr_addr <= LEN_W'(MAX_LEN)) begin
                        fail_mem[wr_addr] <= wr_data[LEN_W-1:0];
                    end
                end
                SEL_LEN: begin
                    len_q <= (wr_data > CHAR_W'(MAX_LEN)) ? LEN_W'(MAX_LEN)
                                                          : wr_data[LEN_W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        fail_j   = fail_mem[j];
        pat_j    = pat_mem[j[PIDX_W-1:0]];
        pat_fj   = pat_mem[fail_j[PIDX_W-1:0]];
        fail_len = fail_mem[len_q];
        len      = len_q;
    end

endmodule

// File: rtl/kmp_step_unit.sv
module kmp_step_unit
    import kmp_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int LEN_W  = 5
) (
    input  logic              head_valid,
    input  logic [CHAR_W-1:0] head,
    input  logic [LEN_W-1:0]  j,
    input  logic [LEN_W-1:0]  len,
    input  logic [CHAR_W-1:0] pat_j,
    input  logic [CHAR_W-1:0] pat_fj,
    input  logic [LEN_W-1:0]  fail_j,
    input  logic [LEN_W-1:0]  fail_len,
    output logic              consume,
    output logic              full_hit,
    output logic [LEN_W-1:0]  j_next
);
    step_t            step;
    logic [LEN_W-1:0] j_adv;
    logic             hit_a;
    logic             hit_b;

    always_comb begin
        hit_a = (head == pat_j);
        hit_b = (head == pat_fj);
        step  = STEP_NONE;
        j_adv = j;
        if (head_valid) begin
            if (len == '0) begin
                step  = STEP_SKIP;
                j_adv = '0;
            end else if (hit_a) begin
                step  = STEP_ADVANCE;
                j_adv = j + LEN_W'(1);
            end else if (j == '0) begin
                step  = STEP_SKIP;
                j_adv = '0;
            end else if (hit_b) begin
                step  = STEP_FALLBACK;
                j_adv = fail_j + LEN_W'(1);
            end else begin
                step  = STEP_RETREAT;
                j_adv = fail_j;
            end
        end
        consume  = (step == STEP_ADVANCE) || (step == STEP_FALLBACK) || (step == STEP_SKIP);
        full_hit = (step == STEP_ADVANCE) && (j_adv == len);
        j_next   = full_hit ? fail_len : j_adv;
    end

endmodule

// File: rtl/kmp_stream_matcher.sv
module kmp_stream_matcher
    import kmp_pkg::*;
#(
    parameter int CHAR_W     = 8,
    parameter int MAX_LEN    = 16,
    parameter int FIFO_DEPTH = 4,
    parameter int POS_W      = 16,
    localparam int LEN_W     = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [LEN_W-1:0]  cfg_addr,
    input  logic [CHAR_W-1:0] cfg_data,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              match_pulse,
    output logic [POS_W-1:0]  match_pos,
    output logic              done
);
    mstate_t           state;
    mstate_t           state_nx;
    logic              cfg_take;
    logic              accept;
    logic              fifo_empty;
    logic              fifo_full;
    logic [CHAR_W-1:0] head;
    logic [LEN_W-1:0]  j;
    logic [LEN_W-1:0]  j_next;
    logic [LEN_W-1:0]  len;
    logic [LEN_W-1:0]  fail_j;
    logic [LEN_W-1:0]  fail_len;
    logic [CHAR_W-1:0] pat_j;
    logic [CHAR_W-1:0] pat_fj;
    logic              consume;
    logic              full_hit;
    logic [POS_W-1:0]  pos_cnt;
    logic              match_q;
    logic [POS_W-1:0]  pos_q;

    kmp_char_fifo #(.W(CHAR_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept),
        .push_data (in_data),
        .pop       (consume),
        .head      (head),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    kmp_pattern_store #(.CHAR_W(CHAR_W), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_take),
        .wr_sel   (cfg_sel),
        .wr_addr  (cfg_addr),
        .wr_data  (cfg_data),
        .j        (j),
        .pat_j    (pat_j),
        .pat_fj   (pat_fj),
        .fail_j   (fail_j),
        .fail_len (fail_len),
        .len      (len)
    );

    kmp_step_unit #(.CHAR_W(CHAR_W), .LEN_W(LEN_W)) u_step (
        .head_valid (!fifo_empty),
        .head       (head),
        .j          (j),
        .len        (len),
        .pat_j      (pat_j),
        .pat_fj     (pat_fj),
        .fail_j     (fail_j),
        .fail_len   (fail_len),
        .consume    (consume),
        .full_hit   (full_hit),
        .j_next     (j_next)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (accept) state_nx = in_last ? S_DRAIN : S_RUN;
            S_RUN:    if (accept && in_last) state_nx = S_DRAIN;
            S_DRAIN:  if (fifo_empty) state_nx = S_FINISH;
            S_FINISH: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cfg_take    = cfg_we && (state == S_IDLE);
        in_ready    = !fifo_full && (((state == S_IDLE) && !cfg_we) || (state == S_RUN));
        accept      = in_valid && in_ready;
        done        = (state == S_FINISH);
        match_pulse = match_q;
        match_pos   = pos_q;
    end

    // matcher datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            j       <= '0;
            pos_cnt <= '0;
            match_q <= 1'b0;
            pos_q   <= '0;
        end else begin
            match_q <= full_hit;
            if (full_hit) begin
                pos_q <= pos_cnt;
            end
            if (!fifo_empty) begin
                j <= j_next;
            end
            if (consume) begin
                pos_cnt <= pos_cnt + POS_W'(1);
            end
            if (state == S_FINISH || cfg_take) begin
                j       <= '0;
                pos_cnt <= '0;
            end
        end
    end

    assert_prefix_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (len != '0) |-> (j < len));

    assert_match_in_stream_R1: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> (state == S_RUN || state == S_DRAIN));

    assert_idle_buffer_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> fifo_empty);

    assert_cfg_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |=> $stable(len));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_drained_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fifo_empty && !in_ready));

endmodule

// File: tb/sim_kmp_stream_matcher.sv
module sim_kmp_stream_matcher;

    localparam int CHAR_W  = 8;
    localparam int MAX_LEN = 16;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);
    localparam int POS_W   = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_sel = '0;
    logic [LEN_W-1:0]  cfg_addr = '0;
    logic [CHAR_W-1:0] cfg_data = '0;
    logic              in_valid = 1'b0;
    logic [CHAR_W-1:0] in_data = '0;
    logic              in_last = 1'b0;
    logic              in_ready;
    logic              match_pulse;
    logic [POS_W-1:0]  match_pos;
    logic              done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int expq[$];
    string cur_pat = "";
    bit mon_on = 1'b0;
    bit prev_done = 1'b0;
    bit saw_stall = 1'b0;

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    kmp_stream_matcher u0 (
        .clk (clk), .rst_n (rst_n),
        .cfg_we (cfg_we), .cfg_sel (cfg_sel), .cfg_addr (cfg_addr), .cfg_data (cfg_data),
        .in_valid (in_valid), .in_data (in_data), .in_last (in_last), .in_ready (in_ready),
        .match_pulse (match_pulse), .match_pos (match_pos), .done (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // per-clock comparison against the behavioural occurrence list
    always @(negedge clk) begin
        if (mon_on) begin
            if (match_pulse) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R1 unexpected match", int'(match_pos), -1);
                end else begin
                    int e;
                    e = expq.pop_front();
                    check(int'(match_pos) == e, "R1 match position", int'(match_pos), e);
                end
            end
            if (done && prev_done) begin
                check(1'b0, "R6 done longer than one cycle", 2, 1);
            end
            prev_done = done;
        end
    end

    function automatic int border(input string p, input int k);
        for (int b = k - 1; b > 0; b--) begin
            bit same = 1'b1;
            for (int i = 0; i < b; i++) begin
                if (p[i] != p[k - b + i]) same = 1'b0;
            end
            if (same) return b;
        end
        return 0;
    endfunction

    task automatic cfg_write(input int sel, input int addr, input int data, input bit chk);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_sel  = 2'(sel);
        cfg_addr = LEN_W'(addr);
        cfg_data = CHAR_W'(data);
        #1;
        if (chk) check(in_ready == 1'b0, "R4 ready low during write", int'(in_ready), 0);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_pattern(input string p);
        cur_pat = p;
        cfg_write(2, 0, p.len(), 1'b1);
        for (int i = 0; i < p.len(); i++) cfg_write(0, i, int'(p[i]), 1'b1);
        for (int k = 1; k <= p.len(); k++) cfg_write(1, k, border(p, k), 1'b1);
    endtask

    task automatic build_expect(input string s);
        int L;
        L = cur_pat.len();
        if (L == 0) return;
        for (int i = 0; i + L <= s.len(); i++) begin
            bit same = 1'b1;
            for (int k = 0; k < L; k++) begin
                if (s[i + k] != cur_pat[k]) same = 1'b0;
            end
            if (same) expq.push_back(i + L - 1);
        end
    endtask

    task automatic run_stream(input string s, input bit gaps, input string req);
        int first;
        int waited;
        first = -1;
        build_expect(s);
        for (int i = 0; i < s.len(); i++) begin
            bit took = 1'b0;
            while (!took) begin
                @(negedge clk);
                in_valid = gaps ? ((cyc % 3) != 1) : 1'b1;
                in_data  = CHAR_W'(s[i]);
                in_last  = (i == s.len() - 1);
                #3;
                if (in_valid && !in_ready) saw_stall = 1'b1;
                if (in_valid && in_ready) begin
                    took = 1'b1;
                    if (first < 0) first = cyc;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        #1;
        check(in_ready == 1'b0, "R6 no intake after last beat", int'(in_ready), 0);
        waited = 0;
        while (!done && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        check(done == 1'b1, {req, " R6 done reached"}, int'(done), 1);
        if (!gaps) begin
            check((cyc - first) <= 2 * s.len() + 4, "R8 completion bound",
                  cyc - first, 2 * s.len() + 4);
        end
        @(negedge clk);
        check(expq.size() == 0, {req, " all occurrences reported"}, expq.size(), 0);
        expq.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(match_pulse == 1'b0, "R2 match low after reset", int'(match_pulse), 0);
        check(done == 1'b0, "R2 done low after reset", int'(done), 0);
        check(in_ready == 1'b1, "R2 ready high after reset", int'(in_ready), 1);
        mon_on = 1'b1;

        // R1: overlapping occurrences, continuous and gapped sources
        load_pattern("abab");
        run_stream("abababxababab", 1'b0, "R1");
        run_stream("ababxabab", 1'b1, "R1 gapped");

        // R1: fallback comparator case and single-character pattern
        load_pattern("aab");
        run_stream("aaabaabaaaab", 1'b0, "R1 fallback");
        load_pattern("a");
        run_stream("banana", 1'b0, "R1 length one");

        // R3: retreat cycles fill the buffer
        load_pattern("aaaa");
        saw_stall = 1'b0;
        run_stream("aaaaabaaaaabaaaaabaaaaabaaaaabaaaaab", 1'b0, "R3");
        check(saw_stall == 1'b1, "R3 ready dropped when buffer full", int'(saw_stall), 1);

        // R7: maximum length, overlapping and distinct
        load_pattern("aaaaaaaaaaaaaaaa");
        run_stream("aaaaaaaaaaaaaaaaaaaaaaaa", 1'b0, "R7 max overlap");
        load_pattern("abcdefghijklmnop");
        run_stream("zabcdefghijklmnopabcdefghijklmnopq", 1'b0, "R7 max distinct");

        // R7: length zero never matches
        load_pattern("");
        run_stream("aaaabcd", 1'b0, "R7 length zero");

        // R5: writes during a stream are ignored
        load_pattern("abc");
        fork
            run_stream("xxabcabcxxabcab", 1'b1, "R5 during");
            begin
                repeat (4) @(negedge clk);
                cfg_write(2, 0, 2, 1'b0);
                cfg_write(0, 0, int'("x"), 1'b0);
                cfg_write(1, 2, 1, 1'b0);
            end
        join
        run_stream("abcxabcab", 1'b0, "R5 after");

        // R6: positions restart from zero on a new stream
        run_stream("abc", 1'b0, "R6 restart");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule